// File: doc/BRIEF.md
# Microoperation Decode and Accumulator Datapath

This block carries out the control-word part of a 20-bit microinstruction on a small register file. The file holds a 16-bit accumulator (AC), a 16-bit data register (DR), an 11-bit address register (AR) and an 11-bit program counter (PC). The control word has three 3-bit operation fields, called F1, F2 and F3. Each field is decoded to one-hot form. All transfers the fields select take effect together on one rising clock edge, and each of them reads the register values from before that edge. The remaining 11 bits of the word hold branch condition, branch type and next address. The sequencer uses those bits, and this block ignores them.

Memory is a 2048x16 array outside the block. AR always drives the memory address and DR always drives the write data. A write strobe is raised during the cycle of a store. Read data has to come back combinationally from the current AR, because DR captures it at the same edge. The block also outputs three status signals for the branch logic: the top bit of DR, the top bit of AC, and an AC-zero flag.

Top module: `uop_datapath`

## Requirements
- R1: While rst_ni is low, AC, DR, AR and PC are all zero and mem_we_o is low.
- R2: The field F1 sits at uinstr_i[19:17], F2 at [16:14] and F3 at [13:11]. F1 codes that write AC: 1 gives AC+DR, 2 gives zero, 3 gives AC+1, 4 gives DR. Sums wrap modulo 2^16.
- R3: F1 code 5 loads AR from DR[10:0] and code 6 loads AR from PC. F1 code 7 raises mem_we_o for that cycle only, with mem_addr_o equal to AR and mem_wdata_o equal to DR. mem_we_o is low for every other F1 code.
- R4: F2 codes that write AC: 1 gives AC-DR, 2 gives AC OR DR, 3 gives AC AND DR.
- R5: F2 codes that write DR: 4 loads mem_rdata_i, 5 loads AC, 6 loads DR+1, and 7 loads PC into DR[10:0] while DR[15:11] keeps its value.
- R6: F3 codes that write AC: 1 gives AC XOR DR, 2 gives the bitwise complement, 3 gives a left shift by one, 4 gives a right shift by one. Both shifts fill the vacated bit with 0.
- R7: F3 code 5 increments PC (wrapping at 11 bits) and code 6 loads PC from AR. F3 code 7 changes no register.
- R8: Transfers selected by different fields in the same word all use the register values from before the edge. For example, F1=4 with F2=5 swaps AC and DR.
- R9: When more than one field writes AC in the same word, F3 wins over F2 and F2 wins over F1.
- R10: ac_msb_o equals AC[15], dr_msb_o equals DR[15], and ac_zero_o is high exactly when AC is zero. All three follow the registers without delay.
- R11: uinstr_i[10:0] has no effect on any register or output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| uinstr_i | input | 20 | Current microinstruction |
| mem_rdata_i | input | 16 | Memory data at mem_addr_o |
| mem_addr_o | output | 11 | Memory address (the AR contents) |
| mem_wdata_o | output | 16 | Memory write data (the DR contents) |
| mem_we_o | output | 1 | Memory write strobe |
| ac_o | output | 16 | Accumulator contents |
| pc_o | output | 11 | Program counter contents |
| ac_msb_o | output | 1 | AC sign bit |
| dr_msb_o | output | 1 | DR top bit |
| ac_zero_o | output | 1 | AC equals zero |

## Verification
A wrong next-state value in any of the four registers shows at the ports one edge after the word that caused it. AC and PC appear directly, AR appears as mem_addr_o, and DR appears as mem_wdata_o and dr_msb_o. The status flags show the same fault within that cycle. A fault in the write strobe decode shows within the same cycle as the word, before the edge. A store that goes to the wrong address or carries the wrong data shows later, when a read from the expected address returns a different value into DR.

// File: rtl/uop_pkg.sv
package uop_pkg;
  localparam int unsigned FLD_W  = 3;
  localparam int unsigned N_FLD  = 3;
  localparam int unsigned N_CODE = 1 << FLD_W;

  typedef enum logic [FLD_W-1:0] {
    A_NOP, A_ADD, A_CLR, A_INC, A_LDDR, A_ARDR, A_ARPC, A_WR
  } fa_e;

  typedef enum logic [FLD_W-1:0] {
    B_NOP, B_SUB, B_OR, B_AND, B_RD, B_DRAC, B_DRINC, B_DRPC
  } fb_e;

  typedef enum logic [FLD_W-1:0] {
    C_NOP, C_XOR, C_COM, C_SHL, C_SHR, C_PCINC, C_PCAR, C_RSV
  } fc_e;
endpackage

// File: rtl/uop_field_dec.sv
module uop_field_dec #(
  parameter int unsigned SEL_W = 3,
  localparam int unsigned N = 1 << SEL_W
) (
  input  logic [SEL_W-1:0] sel_i,
  output logic [N-1:0]     hot_o
);
  for (genvar i = 0; i < N; i++) begin : g_hot
    assign hot_o[i] = (sel_i == SEL_W'(i));
  end
endmodule

// File: rtl/uop_ac_unit.sv
module uop_ac_unit
  import uop_pkg::*;
#(
  parameter int unsigned DW = 16
) (
  input  logic [DW-1:0]     ac_i,
  input  logic [DW-1:0]     dr_i,
  input  logic [N_CODE-1:0] fa_hot_i,
  input  logic [N_CODE-1:0] fb_hot_i,
  input  logic [N_CODE-1:0] fc_hot_i,
  output logic [DW-1:0]     ac_d_o
);
  // later assignments win: F3 > F2 > F1
  always_comb begin
    ac_d_o = ac_i;
    if (fa_hot_i[A_ADD])  ac_d_o = ac_i + dr_i;
    if (fa_hot_i[A_CLR])  ac_d_o = '0;
    if (fa_hot_i[A_INC])  ac_d_o = ac_i + DW'(1);
    if (fa_hot_i[A_LDDR]) ac_d_o = dr_i;
    if (fb_hot_i[B_SUB])  ac_d_o = ac_i - dr_i;
    if (fb_hot_i[B_OR])   ac_d_o = ac_i | dr_i;
    if (fb_hot_i[B_AND])  ac_d_o = ac_i & dr_i;
    if (fc_hot_i[C_XOR])  ac_d_o = ac_i ^ dr_i;
    if (fc_hot_i[C_COM])  ac_d_o = ~ac_i;
    if (fc_hot_i[C_SHL])  ac_d_o = {ac_i[DW-2:0], 1'b0};
    if (fc_hot_i[C_SHR])  ac_d_o = {1'b0, ac_i[DW-1:1]};
  end
endmodule

// File: rtl/uop_xfer_unit.sv
module uop_xfer_unit
  import uop_pkg::*;
#(
  parameter int unsigned DW = 16,
  parameter int unsigned AW = 11
) (
  input  logic [DW-1:0]     ac_i,
  input  logic [DW-1:0]     dr_i,
  input  logic [AW-1:0]     ar_i,
  input  logic [AW-1:0]     pc_i,
  input  logic [DW-1:0]     rdata_i,
  input  logic [N_CODE-1:0] fa_hot_i,
  input  logic [N_CODE-1:0] fb_hot_i,
  input  logic [N_CODE-1:0] fc_hot_i,
  output logic [DW-1:0]     dr_d_o,
  output logic [AW-1:0]     ar_d_o,
  output logic [AW-1:0]     pc_d_o
);
  logic          ar_from_pc;
  logic [AW-1:0] ar_src;

  assign ar_from_pc = fa_hot_i[A_ARPC];
  assign ar_src     = ar_from_pc ? pc_i : dr_i[AW-1:0];

  always_comb begin
    ar_d_o = ar_i;
    if (fa_hot_i[A_ARDR] || fa_hot_i[A_ARPC]) ar_d_o = ar_src;
  end

  always_comb begin
    dr_d_o = dr_i;
    if (fb_hot_i[B_RD])    dr_d_o = rdata_i;
    if (fb_hot_i[B_DRAC])  dr_d_o = ac_i;
    if (fb_hot_i[B_DRINC]) dr_d_o = dr_i + DW'(1);
    if (fb_hot_i[B_DRPC])  dr_d_o = {dr_i[DW-1:AW], pc_i};
  end

  always_comb begin
    pc_d_o = pc_i;
    if (fc_hot_i[C_PCINC]) pc_d_o = pc_i + AW'(1);
    if (fc_hot_i[C_PCAR])  pc_d_o = ar_i;
  end
endmodule

// File: rtl/uop_datapath.sv
module uop_datapath
  import uop_pkg::*;
#(
  parameter int unsigned DW    = 16,
  parameter int unsigned AW    = 11,
  parameter int unsigned SEQ_W = 11,
  localparam int unsigned UI_W = N_FLD * FLD_W + SEQ_W
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [UI_W-1:0] uinstr_i,
  input  logic [DW-1:0]   mem_rdata_i,
  output logic [AW-1:0]   mem_addr_o,
  output logic [DW-1:0]   mem_wdata_o,
  output logic            mem_we_o,
  output logic [DW-1:0]   ac_o,
  output logic [AW-1:0]   pc_o,
  output logic            ac_msb_o,
  output logic            dr_msb_o,
  output logic            ac_zero_o
);
  logic [N_FLD-1:0][FLD_W-1:0]  fsel;
  logic [N_FLD-1:0][N_CODE-1:0] fhot;

  for (genvar g = 0; g < N_FLD; g++) begin : g_dec
    assign fsel[g] = uinstr_i[UI_W-1-g*FLD_W -: FLD_W];
    uop_field_dec #(.SEL_W(FLD_W)) i_dec (
      .sel_i (fsel[g]),
      .hot_o (fhot[g])
    );
  end

  logic [DW-1:0] ac_q, ac_d, dr_q, dr_d;
  logic [AW-1:0] ar_q, ar_d, pc_q, pc_d;

  uop_ac_unit #(.DW(DW)) i_ac (
    .ac_i     (ac_q),
    .dr_i     (dr_q),
    .fa_hot_i (fhot[0]),
    .fb_hot_i (fhot[1]),
    .fc_hot_i (fhot[2]),
    .ac_d_o   (ac_d)
  );

  uop_xfer_unit #(.DW(DW), .AW(AW)) i_xfer (
    .ac_i     (ac_q),
    .dr_i     (dr_q),
    .ar_i     (ar_q),
    .pc_i     (pc_q),
    .rdata_i  (mem_rdata_i),
    .fa_hot_i (fhot[0]),
    .fb_hot_i (fhot[1]),
    .fc_hot_i (fhot[2]),
    .dr_d_o   (dr_d),
    .ar_d_o   (ar_d),
    .pc_d_o   (pc_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ac_q <= '0;
      dr_q <= '0;
      ar_q <= '0;
      pc_q <= '0;
    end else begin
      ac_q <= ac_d;
      dr_q <= dr_d;
      ar_q <= ar_d;
      pc_q <= pc_d;
    end
  end

  assign mem_addr_o  = ar_q;
  assign mem_wdata_o = dr_q;
  assign mem_we_o    = rst_ni && fhot[0][A_WR];
  assign ac_o        = ac_q;
  assign pc_o        = pc_q;
  assign ac_msb_o    = ac_q[DW-1];
  assign dr_msb_o    = dr_q[DW-1];
  assign ac_zero_o   = ~|ac_q;

  // R1: strobe quiet while in reset
  always_comb begin
    if (!rst_ni) assert_no_we_in_reset_R1: assert (!mem_we_o);
  end

  assert_ar_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fsel[0] != A_ARDR && fsel[0] != A_ARPC) |=> $stable(ar_q));

  assert_pc_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fsel[2] != C_PCINC && fsel[2] != C_PCAR) |=> $stable(pc_q));

  assert_pc_inc_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fsel[2] == C_PCINC) |=> pc_q == $past(pc_q) + AW'(1));

  assert_swap_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fsel[0] == A_LDDR && fsel[1] == B_DRAC && fsel[2] == C_NOP)
    |=> (ac_q == $past(dr_q) && dr_q == $past(ac_q)));

  assert_clr_zero_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fsel[0] == A_CLR && fsel[1] == B_NOP && fsel[2] == C_NOP) |=> ac_zero_o);

  assert_com_wins_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fsel[2] == C_COM) |=> ac_q == ~$past(ac_q));
endmodule

// File: tb/test_uop_datapath.sv
module test_uop_datapath;
  localparam int CLK_PERIOD = 10;

  typedef struct {
    logic [15:0] ac;
    logic [15:0] dr;
    logic [10:0] ar;
    logic [10:0] pc;
    string       tag;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [19:0] ui = '0;
  logic [15:0] rdata;
  logic [10:0] maddr;
  logic [15:0] wdata;
  logic        we;
  logic [15:0] ac;
  logic [10:0] pc;
  logic        ac_msb, dr_msb, ac_zero;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  logic [15:0] mem [2048];
  logic [15:0] emem [2048];
  logic [15:0] m_ac = '0, m_dr = '0;
  logic [10:0] m_ar = '0, m_pc = '0;
  exp_t q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  uop_datapath i_uop_datapath (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .uinstr_i    (ui),
    .mem_rdata_i (rdata),
    .mem_addr_o  (maddr),
    .mem_wdata_o (wdata),
    .mem_we_o    (we),
    .ac_o        (ac),
    .pc_o        (pc),
    .ac_msb_o    (ac_msb),
    .dr_msb_o    (dr_msb),
    .ac_zero_o   (ac_zero)
  );

  assign rdata = mem[maddr];
  always @(posedge clk) if (we) mem[maddr] <= wdata;

  function automatic logic [19:0] mk(input logic [2:0] a, b, c);
    return {a, b, c, 11'h2A5};
  endfunction

  task automatic chk(input bit ok, input string msg);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s", msg);
    end
  endtask

  // driver: drive word, predict, push expectation
  task automatic apply(input logic [19:0] w, input string tag);
    logic [2:0]  a, b, c;
    logic [15:0] nac, ndr;
    logic [10:0] nar, npc;
    exp_t e;
    @(negedge clk);
    ui = w;
    a = w[19:17]; b = w[16:14]; c = w[13:11];
    nac = m_ac; ndr = m_dr; nar = m_ar; npc = m_pc;
    case (a)
      3'd1: nac = m_ac + m_dr;
      3'd2: nac = '0;
      3'd3: nac = m_ac + 16'd1;
      3'd4: nac = m_dr;
      3'd5: nar = m_dr[10:0];
      3'd6: nar = m_pc;
      default: ;
    endcase
    case (b)
      3'd1: nac = m_ac - m_dr;
      3'd2: nac = m_ac | m_dr;
      3'd3: nac = m_ac & m_dr;
      3'd4: ndr = emem[m_ar];
      3'd5: ndr = m_ac;
      3'd6: ndr = m_dr + 16'd1;
      3'd7: ndr = {m_dr[15:11], m_pc};
      default: ;
    endcase
    case (c)
      3'd1: nac = m_ac ^ m_dr;
      3'd2: nac = ~m_ac;
      3'd3: nac = m_ac << 1;
      3'd4: nac = m_ac >> 1;
      3'd5: npc = m_pc + 11'd1;
      3'd6: npc = m_ar;
      default: ;
    endcase
    #1;
    chk(we == (a == 3'd7), $sformatf("R3 %s we=%0b exp=%0b", tag, we, a == 3'd7));
    if (a == 3'd7)
      chk(maddr == m_ar && wdata == m_dr,
          $sformatf("R3 %s addr/data=%h/%h exp=%h/%h", tag, maddr, wdata, m_ar, m_dr));
    if (a == 3'd7) emem[m_ar] = m_dr;
    m_ac = nac; m_dr = ndr; m_ar = nar; m_pc = npc;
    e.ac = nac; e.dr = ndr; e.ar = nar; e.pc = npc; e.tag = tag;
    q.push_back(e);
  endtask

  // monitor: compare after each edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        chk(ac == e.ac && wdata == e.dr && maddr == e.ar && pc == e.pc,
            $sformatf("%s ac/dr/ar/pc=%h/%h/%h/%h exp=%h/%h/%h/%h", e.tag,
                      ac, wdata, maddr, pc, e.ac, e.dr, e.ar, e.pc));
        chk(ac_msb == e.ac[15] && dr_msb == e.dr[15] && ac_zero == (e.ac == 16'd0),
            $sformatf("R10 %s flags=%b%b%b exp=%b%b%b", e.tag, ac_msb, dr_msb, ac_zero,
                      e.ac[15], e.dr[15], e.ac == 16'd0));
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 2048; i++) begin
      mem[i]  = 16'(i * 16'h1357) ^ 16'h8005;
      emem[i] = mem[i];
    end
    repeat (3) @(negedge clk);
    #1;
    chk(ac == 0 && wdata == 0 && maddr == 0 && pc == 0 && !we,
        $sformatf("R1 reset ac/dr/ar/pc/we=%h/%h/%h/%h/%b exp=0", ac, wdata, maddr, pc, we));
    @(negedge clk);
    rst_n = 1'b1;

    apply(mk(0, 4, 0), "R5 read");
    apply(mk(4, 0, 0), "R2 ac<-dr");
    apply(mk(3, 0, 0), "R2 inc");
    apply(mk(1, 0, 0), "R2 add");
    apply(mk(2, 0, 0), "R2 clr");
    apply(mk(3, 0, 5), "R7 incpc");
    apply(mk(0, 0, 5), "R7 incpc");
    apply(mk(0, 0, 5), "R7 incpc");
    apply(mk(6, 0, 0), "R3 ar<-pc");
    apply(mk(0, 4, 0), "R5 read ar");
    apply(mk(5, 0, 0), "R3 ar<-dr");
    apply(mk(0, 0, 6), "R7 pc<-ar");
    apply(mk(0, 7, 0), "R5 dr<-pc");
    apply(mk(0, 6, 0), "R5 incdr");
    apply(mk(0, 5, 0), "R5 dr<-ac");
    apply(mk(4, 6, 0), "R8 ac<-dr,incdr");
    apply(mk(7, 0, 0), "R3 write");
    apply(mk(0, 0, 0), "R3 we drop");
    apply(mk(0, 4, 0), "R3 readback");
    apply(mk(0, 1, 0), "R4 sub");
    apply(mk(0, 2, 0), "R4 or");
    apply(mk(0, 3, 0), "R4 and");
    apply(mk(0, 0, 1), "R6 xor");
    apply(mk(0, 0, 2), "R6 com");
    apply(mk(0, 0, 3), "R6 shl");
    apply(mk(0, 0, 4), "R6 shr");
    apply(mk(3, 0, 2), "R6 com");
    apply(mk(0, 0, 3), "R6 shl msb");
    apply(mk(0, 0, 7), "R7 reserved");
    apply(mk(3, 0, 0), "R8 prep");
    apply(mk(4, 5, 0), "R8 swap");
    apply(mk(1, 1, 2), "R9 f3 wins");
    apply(mk(2, 2, 0), "R9 f2 wins");
    apply(mk(7, 4, 5), "R8 write+read+incpc");
    apply({9'b0, 11'h7FF}, "R11 seq bits");
    apply({3'd0, 3'd0, 3'd7, 11'h555}, "R11 seq bits rsv");
    apply(mk(0, 0, 0), "R11 idle");
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule